// File: doc/BRIEF.md
# SYSREF Frame and Multiframe Aligner

This block keeps a frame count and a multiframe count running in the sample clock domain, with one frame per sample clock cycle. It locks the phase of the multiframe boundary to the rising edges of a synchronous SYSREF level. The level only reaches the edge detector while a detection gate is enabled. The multiframe length K is taken from a configuration input.

The first gated rising edge after reset always sets the phase. Every later edge is checked against the running count. An edge that falls on the multiframe grid leaves the counters alone. An edge off the grid restarts the count and raises a one-cycle realign pulse, which tells the link layer that the link must be rebuilt. The gate output is the AND of the enable and the SYSREF level. So turning the gate on while SYSREF is already high creates a false edge, and the next real edge then sets the intended phase.

Reset is asynchronous and active low. Its release is synchronized internally over two clock edges.

Top module: `sysref_aligner`

## Requirements
- R1: While reset is asserted, and for the two cycles of synchronized release, `frame_stb`, `lmfc_stb`, `realign_pls` and `aligned` are all 0.
- R2: After reset the multiframe counter starts at 0 with length 16 (K_DEF). `lmfc_stb` is high in each cycle where the counter is 0, so with no SYSREF it pulses every K cycles.
- R3: `frame_stb` is high in every cycle once reset release has completed, because one frame equals one sample clock.
- R4: The SYSREF level reaches edge detection only as `gate_en AND sysref_lvl`. Edges that arrive while the gate is low cause no realign pulse and do not set `aligned`.
- R5: Suppose the gated level is sampled 0 at one clock edge n-1 and 1 at clock edge n. Then edge n+1 makes a decision, and in the following cycle the counter is 0, `lmfc_stb` is high and, if realigning, `realign_pls` is high. The first such edge after reset always realigns.
- R6: A later edge whose decision cycle finds the counter at K-1 (the counter would reach 0 anyway) is in phase. It produces no pulse and leaves the count undisturbed.
- R7: Any other edge restarts the counter at 0 and produces a `realign_pls` exactly one cycle wide.
- R8: Enabling the gate while `sysref_lvl` is already high counts as a rising edge and realigns. The next real SYSREF rising edge realigns again if it is off the new grid.
- R9: `aligned` rises together with the first realign pulse after reset and stays high until reset.
- R10: A new `k_cfg` value is taken only when the counter wraps or realigns, so a running multiframe is never shortened. Values below 2 are used as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one frame per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sysref_lvl | input | 1 | Synchronous SYSREF level |
| gate_en | input | 1 | SYSREF detection gate enable |
| k_cfg | input | K_W | Frames per multiframe |
| frame_stb | output | 1 | Frame strobe, high every running cycle |
| lmfc_stb | output | 1 | Multiframe boundary strobe |
| realign_pls | output | 1 | One-cycle link-break/realign pulse |
| aligned | output | 1 | Sticky flag: phase set since reset |

## Verification
The bench builds the block with K_W = 6 and K_DEF = 16. This allows K values of 16, 20 and 32, and the clamp case of a configured K of 1, all within one run. A six-bit count lets the bench measure multiframe intervals directly, including the interval right after K changes in the middle of a period. Edges are placed on the grid, a few cycles off it, and as a false edge from the gate, so every branch of the phase decision is reached.

// File: rtl/sysref_al_pkg.sv
package sysref_al_pkg;
  // outcome of the phase decision in one cycle
  typedef enum logic [1:0] {
    EV_IDLE    = 2'd0,
    EV_INPHASE = 2'd1,
    EV_REALIGN = 2'd2
  } sr_event_e;
endpackage

// File: rtl/sr_gate_edge.sv
module sr_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sysref_lvl,
  input  logic gate_en,
  output logic edge_o
);
  logic lvl_q, lvl_d;
  logic prev_q, prev_d;

  always_comb begin
    lvl_d  = gate_en & sysref_lvl;
    prev_d = lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      prev_q <= prev_d;
    end
  end

  assign edge_o = lvl_q & ~prev_q;
endmodule

// File: rtl/sr_lmfc_ctr.sv
module sr_lmfc_ctr #(
  parameter int K_W   = 6,
  parameter int K_DEF = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [K_W-1:0] k_cfg,
  input  logic           restart,
  output logic           at_last,
  output logic           frame_stb,
  output logic           lmfc_stb
);
  localparam logic [K_W-1:0] KMIN  = K_W'(2);
  localparam logic [K_W-1:0] KRST  = K_W'(K_DEF);
  localparam logic [K_W-1:0] ONE   = K_W'(1);

  logic [K_W-1:0] cnt_q, cnt_d;
  logic [K_W-1:0] k_q, k_d;
  logic [K_W-1:0] k_req;
  logic           run_q, run_d;
  logic           load;

  always_comb begin
    k_req   = (k_cfg < KMIN) ? KMIN : k_cfg;
    at_last = (cnt_q == k_q - ONE);
    load    = restart | at_last;
    cnt_d   = load ? '0 : cnt_q + ONE;
    k_d     = load ? k_req : k_q;
    run_d   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      k_q   <= KRST;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      k_q   <= k_d;
      run_q <= run_d;
    end
  end

  assign frame_stb = run_q;
  assign lmfc_stb  = run_q & (cnt_q == '0);
endmodule

// File: rtl/sr_phase_chk.sv
module sr_phase_chk
  import sysref_al_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  input  logic at_last_i,
  output logic restart_o,
  output logic realign_pls,
  output logic aligned
);
  sr_event_e ev;
  logic      pls_q, pls_d;
  logic      al_q, al_d;

  always_comb begin
    if (!edge_i)                 ev = EV_IDLE;
    else if (al_q && at_last_i)  ev = EV_INPHASE;
    else                         ev = EV_REALIGN;
    restart_o = (ev == EV_REALIGN);
    pls_d     = restart_o;
    al_d      = al_q | restart_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pls_q <= 1'b0;
      al_q  <= 1'b0;
    end else begin
      pls_q <= pls_d;
      al_q  <= al_d;
    end
  end

  assign realign_pls = pls_q;
  assign aligned     = al_q;
endmodule

// File: rtl/sysref_aligner.sv
module sysref_aligner #(
  parameter int K_W   = 6,
  parameter int K_DEF = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sysref_lvl,
  input  logic           gate_en,
  input  logic [K_W-1:0] k_cfg,
  output logic           frame_stb,
  output logic           lmfc_stb,
  output logic           realign_pls,
  output logic           aligned
);
  logic [1:0] rs_q, rs_d;
  logic       rst_n_i;
  logic       sr_edge;
  logic       restart;
  logic       at_last;

  // reset: asserted at once, released after two edges
  always_comb rs_d = {rs_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= rs_d;
  end

  assign rst_n_i = rs_q[1];

  sr_gate_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .sysref_lvl (sysref_lvl),
    .gate_en    (gate_en),
    .edge_o     (sr_edge)
  );

  sr_lmfc_ctr #(.K_W(K_W), .K_DEF(K_DEF)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .k_cfg     (k_cfg),
    .restart   (restart),
    .at_last   (at_last),
    .frame_stb (frame_stb),
    .lmfc_stb  (lmfc_stb)
  );

  sr_phase_chk u_phase (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .edge_i      (sr_edge),
    .at_last_i   (at_last),
    .restart_o   (restart),
    .realign_pls (realign_pls),
    .aligned     (aligned)
  );
endmodule

// File: rtl/sysref_aligner_chk.sv
module sysref_aligner_chk (
  input logic clk,
  input logic rst_n,
  input logic gate_en,
  input logic frame_stb,
  input logic lmfc_stb,
  input logic realign_pls,
  input logic aligned
);
  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    realign_pls |=> !realign_pls);

  // R5
  realign_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    realign_pls |-> lmfc_stb);

  // R9
  aligned_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aligned |=> aligned);

  // R9
  aligned_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned) |-> realign_pls);

  // R3
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> frame_stb);

  // R4
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gate_en, 2) |-> !realign_pls);
endmodule

bind sysref_aligner sysref_aligner_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gate_en     (gate_en),
  .frame_stb   (frame_stb),
  .lmfc_stb    (lmfc_stb),
  .realign_pls (realign_pls),
  .aligned     (aligned)
);

// File: tb/test_sysref_aligner.sv
module test_sysref_aligner;
  localparam int K_W   = 6;
  localparam int K_DEF = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           sysref_lvl = 1'b0;
  logic           gate_en = 1'b0;
  logic [K_W-1:0] k_cfg = K_W'(16);
  logic           frame_stb, lmfc_stb, realign_pls, aligned;

  int n_cmp = 0, n_bad = 0, rp_cnt = 0, cyc = 0;

  always #10 clk = ~clk;

  sysref_aligner #(.K_W(K_W), .K_DEF(K_DEF)) i_sysref_aligner (
    .clk(clk), .rst_n(rst_n), .sysref_lvl(sysref_lvl), .gate_en(gate_en),
    .k_cfg(k_cfg), .frame_stb(frame_stb), .lmfc_stb(lmfc_stb),
    .realign_pls(realign_pls), .aligned(aligned)
  );

  // behavioural reference
  int m_cnt, m_k;
  bit m_g1, m_g2, m_rp, m_al, m_run, m_rs1, m_rs2;

  always @(posedge clk or negedge rst_n) begin : model
    bit e, w, re;
    int kr;
    if (!rst_n) begin
      m_cnt = 0; m_k = K_DEF; m_g1 = 0; m_g2 = 0; m_rp = 0; m_al = 0;
      m_run = 0; m_rs1 = 0; m_rs2 = 0;
    end else begin
      if (m_rs2) begin
        e  = m_g1 && !m_g2;
        w  = (m_cnt == m_k - 1);
        re = e && !(m_al && w);
        kr = (int'(k_cfg) < 2) ? 2 : int'(k_cfg);
        m_g2 = m_g1;
        m_g1 = gate_en && sysref_lvl;
        m_cnt = (re || w) ? 0 : m_cnt + 1;
        if (re || w) m_k = kr;
        m_rp = re;
        m_al = m_al || re;
        m_run = 1;
      end
      m_rs2 = m_rs1;
      m_rs1 = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (realign_pls) rp_cnt++;
    chk(frame_stb == m_run, "R3 frame_stb", frame_stb, m_run);
    chk(lmfc_stb == (m_run && m_cnt == 0), "R2 lmfc_stb", lmfc_stb, m_run && m_cnt == 0);
    chk(realign_pls == m_rp, "R7 realign_pls", realign_pls, m_rp);
    chk(aligned == m_al, "R9 aligned", aligned, m_al);
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic sr_pulse(input int hi, input int lo);
    sysref_lvl = 1'b1;
    repeat (hi) @(negedge clk);
    sysref_lvl = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic measure(output int iv);
    @(negedge clk);
    while (!lmfc_stb) @(negedge clk);
    iv = 0;
    do begin
      @(negedge clk);
      iv++;
    end while (!lmfc_stb);
  endtask

  initial begin
    int iv, rp0;
    repeat (3) @(negedge clk);
    // R1: all outputs low in reset
    chk(frame_stb == 0, "R1 frame_stb", frame_stb, 0);
    chk(lmfc_stb == 0, "R1 lmfc_stb", lmfc_stb, 0);
    chk(realign_pls == 0 && aligned == 0, "R1 realign/aligned", realign_pls | aligned, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(frame_stb == 0, "R1 sync release", frame_stb, 0);
    repeat (3) @(negedge clk);
    chk(frame_stb == 1, "R3 running", frame_stb, 1);
    measure(iv);
    chk(iv == 16, "R2 default interval", iv, 16);

    // R4: pulses with gate low are ignored
    rp0 = rp_cnt;
    repeat (3) sr_pulse(5, 13);
    chk(rp_cnt == rp0, "R4 gated off pulses", rp_cnt - rp0, 0);
    chk(aligned == 0, "R4 aligned stays low", aligned, 0);

    // R5: first edge realigns
    gate_en = 1'b1;
    @(negedge clk);
    rp0 = rp_cnt;
    sr_pulse(6, 26);
    chk(rp_cnt - rp0 == 1, "R5 first edge", rp_cnt - rp0, 1);
    chk(aligned == 1, "R9 aligned set", aligned, 1);

    // R6: on-grid edges (32 = 2*K) do nothing
    rp0 = rp_cnt;
    repeat (3) sr_pulse(6, 26);
    chk(rp_cnt == rp0, "R6 in-phase edges", rp_cnt - rp0, 0);

    // R7: off-grid edge realigns once, next on-grid edge is quiet
    repeat (5) @(negedge clk);
    rp0 = rp_cnt;
    sr_pulse(6, 26);
    chk(rp_cnt - rp0 == 1, "R7 off-grid edge", rp_cnt - rp0, 1);
    rp0 = rp_cnt;
    sr_pulse(6, 26);
    chk(rp_cnt == rp0, "R6 after realign", rp_cnt - rp0, 0);

    // R8: gate enabled while SYSREF high gives a false edge
    gate_en = 1'b0;
    sysref_lvl = 1'b1;
    repeat (4) @(negedge clk);
    rp0 = rp_cnt;
    gate_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(rp_cnt - rp0 == 1, "R8 false edge", rp_cnt - rp0, 1);
    sysref_lvl = 1'b0;
    repeat (10) @(negedge clk);
    rp0 = rp_cnt;
    sr_pulse(6, 26);
    chk(rp_cnt - rp0 == 1, "R8 real edge realigns", rp_cnt - rp0, 1);
    chk(aligned == 1, "R9 still aligned", aligned, 1);
    gate_en = 1'b0;

    // R10: K changes only at a wrap; K below 2 is used as 2
    repeat (7) @(negedge clk);
    k_cfg = K_W'(20);
    measure(iv);
    chk(iv == 20, "R10 K=20", iv, 20);
    k_cfg = K_W'(1);
    measure(iv);
    chk(iv == 2, "R10 K clamp", iv, 2);
    k_cfg = K_W'(32);
    measure(iv);
    chk(iv == 32, "R10 K=32", iv, 32);
    measure(iv);
    chk(iv == 32, "R10 K=32 repeat", iv, 32);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule